// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible register layer of a serial port. A 32-bit bus with separate read and write strobes reaches seven word registers inside a 0x400-byte window. Received bytes arrive on a valid/ready byte stream and wait in a one-byte holding register until software reads them. Bytes that software writes leave on a one-cycle transmit strobe. A single level interrupt reports that a received byte is waiting.

The block models no serial line timing. The baud-rate, guard-time and two of the control registers only store what software writes and return it on a read. The interesting behaviour sits in the status word, the data port and the first control register. The status word has two write rules, selected by the written value. A read of the data port consumes the byte and lowers the interrupt. A write of the first control register can raise the interrupt for a byte that is already waiting.

Register offsets, decoded from address bits [9:2] with bits [1:0] ignored: status 0x00, data 0x04, baud 0x08, control-1 0x0C, control-2 0x10, control-3 0x14, guard 0x18.

Top module: `sio_regblock`

## Requirements
- R1: After synchronous reset, the status word reads 0x000000C0 and the data, baud, control and guard registers read 0. The interrupt is low and rx_ready is high.
- R2: rx_ready is high exactly when the status byte-waiting flag (bit 5) is clear. A byte offered while rx_ready is low is not taken and leaves the data register unchanged.
- R3: A byte that is taken while control-1 bit 13 (unit on) and bit 2 (receive on) are both set is stored and sets status bit 5.
- R4: A byte that is taken while either enable is clear is discarded: status bit 5 stays clear and the data register keeps its value.
- R5: When a stored byte arrives while control-1 bit 5 (receive interrupt enable) is set, irq rises. If that bit is clear, irq stays low.
- R6: A read of the data port returns the stored byte zero-extended, masked to 10 bits. The same read clears status bit 5 and lowers irq.
- R7: A status write of a value not above 0x3FF loads that value with bit 7 (transmit empty) forced to 1.
- R8: A status write of a value above 0x3FF ANDs the value into the current status.
- R9: After any status write, irq is low if status bit 5 ended up clear. If bit 5 is still set, irq keeps its level.
- R10: A data write of a value below 0xF000 puts its low 8 bits on tx_byte with tx_valid high for one cycle and sets status bit 6 (transfer complete). A value of 0xF000 or more has no effect.
- R11: A control-1 write stores the value. It raises irq if the new value has bit 5 set and status bit 5 is set. It never lowers irq.
- R12: The baud, control-2, control-3 and guard registers store all 32 written bits and read them back unchanged.
- R13: Reads of offsets outside the seven registers return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Holding register free |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
Every result takes one clock edge. A write, a read or an accepted byte presented at an edge changes the status word, irq, tx_valid and bus_rdata at that same edge. rx_ready follows the status word with no added delay. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It then drops tx_valid and confirms the strobe lasts a single cycle. Expected values come from a bench-side model of the status word, built from the two write rules.

// File: rtl/sio_reg_pkg.sv
package sio_reg_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int WIN_AW   = 10;
    localparam int CFG_N    = 5;

    localparam int ST_RXNE  = 5;
    localparam int ST_TC    = 6;
    localparam int ST_TXE   = 7;
    localparam int C1_RE    = 2;
    localparam int C1_RXIE  = 5;
    localparam int C1_UE    = 13;

    localparam logic [WORD_W-1:0] STAT_RST      = 32'h0000_00C0;
    localparam logic [WORD_W-1:0] STAT_LOAD_MAX = 32'h0000_03FF;
    localparam logic [WORD_W-1:0] TX_LIMIT      = 32'h0000_F000;
    localparam logic [WORD_W-1:0] READ_MASK     = 32'h0000_03FF;

    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_BAUD  = 3'd2,
        SEL_CTL1  = 3'd3,
        SEL_CTL2  = 3'd4,
        SEL_CTL3  = 3'd5,
        SEL_GUARD = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode(input logic [WIN_AW-1:0] a);
        if (a[WIN_AW-1:5] != '0) return SEL_NONE;
        return reg_sel_e'(a[4:2]);
    endfunction

    // Storage slot i of the plain configuration bank maps to this selector.
    function automatic reg_sel_e cfg_sel(input int i);
        case (i)
            0:       return SEL_BAUD;
            1:       return SEL_CTL1;
            2:       return SEL_CTL2;
            3:       return SEL_CTL3;
            default: return SEL_GUARD;
        endcase
    endfunction

    // Dual rule: small values load (transmit-empty forced), large values clear by AND.
    function automatic logic [WORD_W-1:0] stat_write(input logic [WORD_W-1:0] cur,
                                                     input logic [WORD_W-1:0] val);
        logic [WORD_W-1:0] r;
        if (val <= STAT_LOAD_MAX) begin
            r = val;
            r[ST_TXE] = 1'b1;
        end else begin
            r = cur & val;
        end
        return r;
    endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_reg_pkg::*;
#(
    parameter int N = CFG_N
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_req_t                  req,
    output logic [N-1:0][WORD_W-1:0]  regs_q
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam reg_sel_e SLOT_SEL = cfg_sel(i);
        logic [WORD_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                               r <= '0;
            else if (req.wr && req.sel == SLOT_SEL) r <= req.wdata;
        end
        assign regs_q[i] = r;
    end

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_reg_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rxne,
    input  logic         rx_enabled,
    output logic         rx_ready,
    output logic         take,
    output logic [W-1:0] data_q
);

    logic fire;

    assign rx_ready = !rxne;
    assign fire     = rx_valid && rx_ready;
    assign take     = fire && rx_enabled;

    always_ff @(posedge clk) begin
        if (rst)       data_q <= '0;
        else if (take) data_q <= rx_byte;
    end

    assert_drop_keeps_data_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !rx_enabled) |=> $stable(data_q));

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !rx_ready);

endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq
    import sio_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              take,
    input  logic              rxie_cur,
    output logic [WORD_W-1:0] stat_q,
    output logic              irq,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [WORD_W-1:0] stat_n;
    logic              irq_n;
    logic              tx_go;

    assign tx_go = req.wr && req.sel == SEL_DATA && req.wdata < TX_LIMIT;

    always_comb begin
        stat_n = stat_q;
        irq_n  = irq;
        if (req.wr) begin
            case (req.sel)
                SEL_STAT: begin
                    stat_n = stat_write(stat_q, req.wdata);
                    if (!stat_n[ST_RXNE]) irq_n = 1'b0;
                end
                SEL_DATA: if (tx_go) stat_n[ST_TC] = 1'b1;
                SEL_CTL1: if (req.wdata[C1_RXIE] && stat_q[ST_RXNE]) irq_n = 1'b1;
                default: ;
            endcase
        end
        if (req.rd && req.sel == SEL_DATA) begin
            stat_n[ST_RXNE] = 1'b0;
            irq_n           = 1'b0;
        end
        // An arriving byte wins over a same-cycle clear.
        if (take) begin
            stat_n[ST_RXNE] = 1'b1;
            if (rxie_cur) irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= STAT_RST;
            irq      <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            stat_q   <= stat_n;
            irq      <= irq_n;
            tx_valid <= tx_go;
            if (tx_go) tx_byte <= req.wdata[BYTE_W-1:0];
        end
    end

    assert_irq_on_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (take && rxie_cur) |=> irq);

    assert_read_drops_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_DATA && !take) |=> !irq);

    assert_load_drops_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_STAT && req.wdata <= STAT_LOAD_MAX
         && !req.wdata[ST_RXNE] && !take) |=> !irq);

    assert_tx_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_DATA && req.wdata >= TX_LIMIT) |=> !tx_valid);

    assert_txe_forced_R7: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_STAT && req.wdata <= STAT_LOAD_MAX) |=> stat_q[ST_TXE]);

endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
    import sio_reg_pkg::*;
#(
    parameter int AW = WIN_AW,
    parameter int DW = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [BW-1:0] rx_byte,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [BW-1:0] tx_byte,
    output logic          irq
);

    localparam int PAD_W = DW - BW;

    bus_req_t                   req;
    logic [CFG_N-1:0][DW-1:0]   cfg_q;
    logic [DW-1:0]              stat_q;
    logic [BW-1:0]              data_q;
    logic                       take;
    logic [DW-1:0]              ctl1;
    logic                       rx_on;
    logic [DW-1:0]              rd_mux;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = decode(bus_addr);
    assign req.wdata = bus_wdata;

    assign ctl1  = cfg_q[1];
    assign rx_on = ctl1[C1_UE] && ctl1[C1_RE];

    sio_cfg_regs #(.N(CFG_N)) i_cfg (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .regs_q (cfg_q)
    );

    sio_rx_hold #(.W(BW)) i_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rxne       (stat_q[ST_RXNE]),
        .rx_enabled (rx_on),
        .rx_ready   (rx_ready),
        .take       (take),
        .data_q     (data_q)
    );

    sio_status_irq i_stat (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .take     (take),
        .rxie_cur (ctl1[C1_RXIE]),
        .stat_q   (stat_q),
        .irq      (irq),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    always_comb begin
        case (req.sel)
            SEL_STAT:  rd_mux = stat_q;
            SEL_DATA:  rd_mux = {{PAD_W{1'b0}}, data_q} & READ_MASK;
            SEL_BAUD:  rd_mux = cfg_q[0];
            SEL_CTL1:  rd_mux = cfg_q[1];
            SEL_CTL2:  rd_mux = cfg_q[2];
            SEL_CTL3:  rd_mux = cfg_q[3];
            SEL_GUARD: rd_mux = cfg_q[4];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && req.sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/test_sio_regblock.sv
module test_sio_regblock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sio_regblock i_sio_regblock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .irq(irq)
    );

    localparam logic [9:0] A_ST = 10'h00, A_DT = 10'h04, A_BD = 10'h08, A_C1 = 10'h0C,
                           A_C2 = 10'h10, A_C3 = 10'h14, A_GT = 10'h18;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, st;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 1);
        rd(A_ST, v); chk("R1 status", v, 32'hC0);
        for (int i = 1; i < 7; i++) begin
            rd(10'(i * 4), v); chk("R1 reg", v, 0);
        end

        // R12 plain registers store full width
        for (int k = 0; k < 8; k++) begin
            logic [31:0] p;
            p = (32'h1 << (k * 4)) ^ (32'hA5C3_0F96 * (k + 1));
            wr(A_BD, p); wr(A_C2, ~p); wr(A_C3, p ^ 32'hFFFF0000); wr(A_GT, p + 1);
            rd(A_BD, v); chk("R12 baud", v, p);
            rd(A_C2, v); chk("R12 ctl2", v, ~p);
            rd(A_C3, v); chk("R12 ctl3", v, p ^ 32'hFFFF0000);
            rd(A_GT, v); chk("R12 guard", v, p + 1);
        end

        // R4 receive with an enable missing
        for (int m = 0; m < 3; m++) begin
            logic [31:0] c;
            c = (m == 0) ? 32'h0 : (m == 1) ? 32'h2000 : 32'h0004;
            wr(A_C1, c | 32'h20);
            send(8'h3C);
            chk("R4 rx_ready", {31'b0, rx_ready}, 1);
            chk("R4 irq", {31'b0, irq}, 0);
            rd(A_ST, v); chk("R4 status", v, 32'hC0);
            rd(A_DT, v); chk("R4 data", v, 0);
        end

        // R3 R5 R6 R2: every byte value, interrupt off then on
        for (int ie = 0; ie < 2; ie++) begin
            wr(A_C1, ie ? 32'h2024 : 32'h2004);
            for (int b = 0; b < 256; b++) begin
                send(8'(b));
                chk("R2 ready low", {31'b0, rx_ready}, 0);
                chk("R5 irq", {31'b0, irq}, ie);
                rd(A_ST, v); chk("R3 status", v, 32'hE0);
                rd(A_DT, v); chk("R6 data", v, b & 32'h3FF);
                chk("R6 irq low", {31'b0, irq}, 0);
                chk("R6 ready", {31'b0, rx_ready}, 1);
            end
        end

        // R2 byte offered while full is not taken
        send(8'h11);
        send(8'h22);
        rd(A_DT, v); chk("R2 held", v, 32'h11);

        // R11 control-1 write raises, never lowers
        wr(A_C1, 32'h2004);
        send(8'h5A);
        chk("R11 pre", {31'b0, irq}, 0);
        wr(A_C1, 32'h2024);
        chk("R11 raise", {31'b0, irq}, 1);
        wr(A_C1, 32'h2004);
        chk("R11 keep", {31'b0, irq}, 1);
        rd(A_C1, v); chk("R11 store", v, 32'h2004);
        rd(A_DT, v); chk("R6 data", v, 32'h5A);
        chk("R6 irq", {31'b0, irq}, 0);
        wr(A_C1, 32'h2024);
        chk("R11 no rxne", {31'b0, irq}, 0);

        // R9 status write versus interrupt
        send(8'h77);
        chk("R5 irq", {31'b0, irq}, 1);
        wr(A_ST, 32'hFFFF_FFFF);
        chk("R9 keep", {31'b0, irq}, 1);
        wr(A_ST, 32'hFFFF_FFDF);
        chk("R9 drop", {31'b0, irq}, 0);
        rd(A_ST, v); chk("R8 and", v, 32'hC0);
        chk("R2 ready", {31'b0, rx_ready}, 1);
        wr(A_C1, 32'h2004);

        // R7 load rule sweep
        for (int s = 0; s < 24; s++) begin
            logic [31:0] val;
            val = (s * 32'h2B) & 32'h3FF;
            if (s == 23) val = 32'h3FF;
            wr(A_ST, val);
            rd(A_ST, v); chk("R7 load", v, val | 32'h80);
        end

        // R8 AND rule sweep
        st = 32'h3FF;
        wr(A_ST, st);
        for (int s = 0; s < 12; s++) begin
            logic [31:0] msk;
            msk = 32'hFFFF_FC00 | ~(32'h1 << s);
            wr(A_ST, msk);
            st = st & msk;
            rd(A_ST, v); chk("R8 and", v, st);
        end
        wr(A_ST, 32'h400);
        rd(A_ST, v); chk("R8 clear all", v, 0);

        // R10 transmit boundary
        for (int t = 0; t < 6; t++) begin
            logic [31:0] d;
            logic        go;
            case (t)
                0: d = 32'h1A5;
                1: d = 32'hEFFF;
                2: d = 32'hF000;
                3: d = 32'hFFFF_FFFF;
                4: d = 32'h0;
                default: d = 32'hF001;
            endcase
            go = d < 32'hF000;
            wr(A_ST, 32'h0);
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = A_DT; bus_wdata = d;
            @(negedge clk);
            bus_wr = 1'b0;
            chk("R10 valid", {31'b0, tx_valid}, go);
            if (go) chk("R10 byte", {24'b0, tx_byte}, d & 32'hFF);
            @(negedge clk);
            chk("R10 pulse", {31'b0, tx_valid}, 0);
            rd(A_ST, v); chk("R10 tc", v, go ? 32'hC0 : 32'h80);
        end

        // R13 unmapped offsets
        wr(A_BD, 32'h1234_5678);
        wr(10'h1C, 32'hDEAD_BEEF);
        wr(10'h3FC, 32'hDEAD_BEEF);
        wr(10'h020, 32'hDEAD_BEEF);
        rd(10'h1C, v);  chk("R13 read", v, 0);
        rd(10'h200, v); chk("R13 read", v, 0);
        rd(A_BD, v);    chk("R13 no write", v, 32'h1234_5678);
        rd(10'h0B, v);  chk("R13 low bits", v, 32'h1234_5678);
        rd(A_ST, v);    chk("R13 status", v, 32'h80);

        finish_run();
    end

endmodule